// File: doc/BRIEF.md
# Reset Phase Clock Controller

This block takes a chip from a pin reset into normal running in three steps and decides, in each step, how fast each internal clock domain ticks. While the asynchronous active-low reset pin is held low (phase 1) and for a fixed stretch after it is released (phase 2), every domain runs at one common slow rate of one eighth of the reference clock. Once the stretch has expired (phase 3), the internal reset is released, the CPU domain runs at the full reference rate, and the peripheral and memory-interface domains run at half rate. A third clock-out pin runs at one eighth of the reference in every phase.

Domains are driven by single-cycle clock enables on the reference clock. The two clock-out pins carry registered divided clock levels. The memory clock-out pin follows the memory-interface clock level when its source select is 0, which is the reset-time default. Every ratio change takes place on a common boundary where all divided levels return low, so no pulse is cut short. The boot strap inputs are captured as the synchronised reset is released and are then held. One output enable per pin group keeps that group tri-stated until phase 3.

Top module: `rst_phase_clkgen`

## Requirements
- R1: While the reset pin is low, `int_rst_n` is 0, every bit of `pin_oe` is 0 and `boot_cfg` is 0 from the second reference edge onward.
- R2: In phases 1 and 2, each of `ce_cpu`, `ce_per` and `ce_mem` is high in exactly 8 of any 64 consecutive reference cycles, one cycle in every 8.
- R3: In phase 3, `ce_cpu` is high on every reference cycle.
- R4: In phase 3, `ce_per` and `ce_mem` are each high in exactly 32 of any 64 consecutive cycles, on alternate cycles.
- R5: `clkout3` is a divide-by-8 clock with 50% duty cycle in every phase: 8 rising edges and 32 high cycles in any 64-cycle window.
- R6: With the default stretch of 16 slow cycles, `int_rst_n` rises between 8*16-4 and 8*16+3 reference edges after the reset pin rises, and only after passing through the stretch phase.
- R7: `boot_cfg` takes the value on `boot_straps` when the synchronised reset releases (2 to 3 reference edges after the pin rises) and holds it, whatever the straps do, until the next reset.
- R8: All bits of `pin_oe` stay 0 through phases 1 and 2 and are all 1 in phase 3.
- R9: Ratio changes happen only at the common boundary: in the first cycle with `int_rst_n` high, `clkout3` and `eclkout` are both 0.
- R10: With `eclk_sel` = 0, `eclkout` is a divided clock with 8 rising edges per 64 cycles in phases 1 and 2 and 32 in phase 3. With `eclk_sel` = 1, `eclkout` is held at 0.
- R11: Pulling the reset pin low during phase 3 returns the block to phase 1: after the next reference edge, `int_rst_n` and every `pin_oe` bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| eclk_sel | input | 1 | Memory clock-out source select: 0 mirrors the memory clock, 1 holds it low |
| boot_straps | input | BOOT_W (3) | Boot and configuration strap inputs |
| int_rst_n | output | 1 | Stretched internal reset, active low |
| ce_cpu | output | 1 | CPU domain clock enable |
| ce_per | output | 1 | Peripheral domain clock enable |
| ce_mem | output | 1 | Memory-interface domain clock enable |
| clkout3 | output | 1 | Divide-by-8 clock-out pin |
| eclkout | output | 1 | Memory clock-out pin |
| boot_cfg | output | BOOT_W (3) | Latched boot configuration |
| pin_oe | output | N_GRP (4) | Output enable per pin group, 1 = drive |

## Verification
On every cycle, the assertions check that the ratio select changes only at the all-low boundary. They also check that the CPU enable is continuous once the block runs fast, that slow enables never come back to back, that phase 3 is only entered from the stretch phase, and that the latched boot value never moves outside the release cycle. The stretch length window, the exact enable and edge counts per phase, the strap capture against later strap changes, and the behaviour of the memory clock-out under both select values can only be shown by the bench's scenarios. The same holds for a reset re-applied from full speed.

// File: rtl/rpc_pkg.sv
// Package: shared types for the reset phase clock controller.
// Assumes: nothing beyond IEEE 1800-2017.
package rpc_pkg;

    // Reset phase: pin held, stretch after release, normal running.
    typedef enum logic [1:0] {
        PH_PIN     = 2'd0,
        PH_STRETCH = 2'd1,
        PH_RUN     = 2'd2
    } phase_e;

endpackage

// File: rtl/rpc_rst_sync.sv
// Module: rpc_rst_sync
// Synchronises the reset pin to the reference clock. The reset asserts at
// once, without a clock, and releases only after STAGES reference edges.
// Assumes: STAGES >= 2.
module rpc_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_pin_n,
    output logic sync_rst_n
);

    logic [STAGES-1:0] shift_q;

    // Shift ones in after release; clear at once when the pin falls.
    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], 1'b1};
        end
    end

    assign sync_rst_n = shift_q[STAGES-1];

endmodule

// File: rtl/rpc_clk_div.sv
// Module: rpc_clk_div
// A free-running counter on the reference clock produces the clock enables
// for the CPU, peripheral and memory domains and the levels of the two
// clock-out pins. run_n chooses the ratios for the next cycle: the slow
// common ratio while it is 0, the per-domain ratio while it is 1.
// All outputs are registered.
// Assumes: every ratio is a power of two no larger than DIV_SLOW.
// DIV_MEM and DIV_OUT3 are at least 2. run_n changes only when bnd is high.
// The counter runs during reset so that slow clocks keep ticking. It starts
// from its declared initial value and wraps on its own.
module rpc_clk_div #(
    parameter int DIV_SLOW = 8,
    parameter int DIV_CPU  = 1,
    parameter int DIV_PER  = 2,
    parameter int DIV_MEM  = 2,
    parameter int DIV_OUT3 = 8
) (
    input  logic clk,
    input  logic sync_rst_n,
    input  logic run_n,
    input  logic run_q,
    input  logic eclk_sel,
    output logic bnd,
    output logic ce_cpu,
    output logic ce_per,
    output logic ce_mem,
    output logic clkout3,
    output logic eclkout
);

    localparam int CW   = $clog2(DIV_SLOW);
    localparam int NDOM = 3;
    localparam int DOM_DIV [NDOM] = '{DIV_CPU, DIV_PER, DIV_MEM};

    logic [CW-1:0]   cnt_q = '0;
    logic [CW-1:0]   cnt_n;
    logic [NDOM-1:0] ce_q = '0;
    logic            clkout3_q = 1'b0;
    logic            eclk_q = 1'b0;

    // Enable is due when the low bits of the count are all ones.
    function automatic logic ce_at(input logic [CW-1:0] c, input int d);
        logic [CW-1:0] mask;
        mask = CW'(d - 1);
        return (c & mask) == mask;
    endfunction

    // Divided clock level: low for the first half of each period.
    function automatic logic lvl_at(input logic [CW-1:0] c, input int d);
        int idx;
        idx = $clog2(d) - 1;
        return c[idx];
    endfunction

    assign cnt_n = cnt_q + 1'b1;
    assign bnd   = &cnt_q;

    // Free-running phase counter; all ratios are derived from it.
    always_ff @(posedge clk) begin
        cnt_q <= cnt_n;
    end

    for (genvar g = 0; g < NDOM; g++) begin : g_dom
        // Enable for domain g, at its own ratio or at the common slow one.
        always_ff @(posedge clk) begin
            ce_q[g] <= ce_at(cnt_n, run_n ? DOM_DIV[g] : DIV_SLOW);
        end
    end

    // Clock-out pin levels, registered to keep the pins glitch free.
    always_ff @(posedge clk) begin
        clkout3_q <= lvl_at(cnt_n, DIV_OUT3);
        eclk_q    <= !eclk_sel && lvl_at(cnt_n, run_n ? DIV_MEM : DIV_SLOW);
    end

    assign ce_cpu  = ce_q[0];
    assign ce_per  = ce_q[1];
    assign ce_mem  = ce_q[2];
    assign clkout3 = clkout3_q;
    assign eclkout = eclk_q;

    // R9: the ratio select moves only on the all-ones count (all levels low next).
    assert_switch_on_boundary_R9: assert property (@(posedge clk) disable iff (!sync_rst_n)
        (run_n != run_q) |-> bnd);

    // R2: at the slow ratio, enables never come on two cycles in a row.
    assert_slow_single_R2: assert property (@(posedge clk) disable iff (!sync_rst_n)
        (!run_q && !run_n && ce_cpu) |=> !ce_cpu);

    if (DIV_CPU == 1) begin : g_cpu_full
        // R3: at full speed the CPU enable is on every cycle.
        assert_cpu_every_cycle_R3: assert property (@(posedge clk) disable iff (!sync_rst_n)
            run_q |-> ce_cpu);
    end

endmodule

// File: rtl/rpc_phase_seq.sv
// Module: rpc_phase_seq
// Reset phase sequencer. It holds phase 1 while the synchronised reset is
// low. It stretches the internal reset for STRETCH_CYC slow boundaries after
// release, then runs. It latches the boot straps on the release cycle. It
// produces the ratio select that the divider applies at each boundary, and
// the pin-group output enables.
// Assumes: bnd marks the last reference cycle of each slow period.
module rpc_phase_seq
    import rpc_pkg::*;
#(
    parameter int STRETCH_CYC = 16,
    parameter int BOOT_W      = 3,
    parameter int N_GRP       = 4
) (
    input  logic              clk,
    input  logic              sync_rst_n,
    input  logic              bnd,
    input  logic [BOOT_W-1:0] boot_straps,
    output logic              run_n,
    output logic              run_q,
    output logic              int_rst_n,
    output logic [BOOT_W-1:0] boot_cfg,
    output logic [N_GRP-1:0]  pin_oe
);

    localparam int SC_W = $clog2(STRETCH_CYC + 1);

    phase_e            phase_q;
    logic [SC_W-1:0]   scnt_q;
    logic [BOOT_W-1:0] boot_q;
    logic              run_r = 1'b0;
    logic              go_run;

    assign go_run = (phase_q == PH_STRETCH) && bnd && (scnt_q == SC_W'(STRETCH_CYC - 1));

    // Phase state and stretch counter, restarted by the synchronised reset.
    always_ff @(posedge clk) begin
        if (!sync_rst_n) begin
            phase_q <= PH_PIN;
            scnt_q  <= '0;
        end else begin
            case (phase_q)
                PH_PIN: phase_q <= PH_STRETCH;
                PH_STRETCH: begin
                    if (go_run) begin
                        phase_q <= PH_RUN;
                    end else if (bnd) begin
                        scnt_q <= scnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_RUN;
            endcase
        end
    end

    // Boot straps captured on the release cycle, then held until reset.
    always_ff @(posedge clk) begin
        if (!sync_rst_n) begin
            boot_q <= '0;
        end else if (phase_q == PH_PIN) begin
            boot_q <= boot_straps;
        end
    end

    // Ratio select: follows the phase, but only at a slow boundary.
    assign run_n = bnd ? (((phase_q == PH_RUN) && sync_rst_n) || go_run) : run_r;

    // Registered ratio select, shared with the divider.
    always_ff @(posedge clk) begin
        run_r <= run_n;
    end

    assign run_q     = run_r;
    assign int_rst_n = (phase_q == PH_RUN);
    assign boot_cfg  = boot_q;

    for (genvar g = 0; g < N_GRP; g++) begin : g_oe
        // Group g drives only in phase 3 with the fast ratios in effect.
        assign pin_oe[g] = (phase_q == PH_RUN) && run_r;
    end

    // R6: phase 3 is never entered straight from phase 1.
    assert_no_skip_R6: assert property (@(posedge clk) disable iff (!sync_rst_n)
        (phase_q == PH_PIN) |=> (phase_q != PH_RUN));

    // R7: the boot value moves only on the release cycle.
    assert_boot_hold_R7: assert property (@(posedge clk) disable iff (!sync_rst_n)
        ((phase_q != PH_PIN) && ($past(phase_q) != PH_PIN)) |-> $stable(boot_q));

    // R8: no pin group drives while the internal reset is held.
    assert_oe_only_running_R8: assert property (@(posedge clk) disable iff (!sync_rst_n)
        (|pin_oe) |-> int_rst_n);

endmodule

// File: rtl/rst_phase_clkgen.sv
// Module: rst_phase_clkgen (top)
// Reset phase clock controller. It synchronises the reset pin, sequences the
// three reset phases and produces domain clock enables, clock-out pin
// levels, the stretched internal reset, the latched boot configuration and
// per-group output enables.
// Assumes: the boot straps are stable for a few reference cycles around the
// reset pin release.
module rst_phase_clkgen #(
    parameter int DIV_SLOW    = 8,
    parameter int DIV_CPU     = 1,
    parameter int DIV_PER     = 2,
    parameter int DIV_MEM     = 2,
    parameter int DIV_OUT3    = 8,
    parameter int STRETCH_CYC = 16,
    parameter int SYNC_STAGES = 2,
    parameter int BOOT_W      = 3,
    parameter int N_GRP       = 4
) (
    input  logic              clk_ref,
    input  logic              rst_pin_n,
    input  logic              eclk_sel,
    input  logic [BOOT_W-1:0] boot_straps,
    output logic              int_rst_n,
    output logic              ce_cpu,
    output logic              ce_per,
    output logic              ce_mem,
    output logic              clkout3,
    output logic              eclkout,
    output logic [BOOT_W-1:0] boot_cfg,
    output logic [N_GRP-1:0]  pin_oe
);

    logic sync_rst_n;
    logic bnd;
    logic run_n;
    logic run_q;

    rpc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk_ref),
        .rst_pin_n  (rst_pin_n),
        .sync_rst_n (sync_rst_n)
    );

    rpc_phase_seq #(
        .STRETCH_CYC (STRETCH_CYC),
        .BOOT_W      (BOOT_W),
        .N_GRP       (N_GRP)
    ) u_seq (
        .clk         (clk_ref),
        .sync_rst_n  (sync_rst_n),
        .bnd         (bnd),
        .boot_straps (boot_straps),
        .run_n       (run_n),
        .run_q       (run_q),
        .int_rst_n   (int_rst_n),
        .boot_cfg    (boot_cfg),
        .pin_oe      (pin_oe)
    );

    rpc_clk_div #(
        .DIV_SLOW (DIV_SLOW),
        .DIV_CPU  (DIV_CPU),
        .DIV_PER  (DIV_PER),
        .DIV_MEM  (DIV_MEM),
        .DIV_OUT3 (DIV_OUT3)
    ) u_div (
        .clk        (clk_ref),
        .sync_rst_n (sync_rst_n),
        .run_n      (run_n),
        .run_q      (run_q),
        .eclk_sel   (eclk_sel),
        .bnd        (bnd),
        .ce_cpu     (ce_cpu),
        .ce_per     (ce_per),
        .ce_mem     (ce_mem),
        .clkout3    (clkout3),
        .eclkout    (eclkout)
    );

    // R11: a synchronised reset forces the internal reset on the next edge.
    assert_reset_forces_phase1_R11: assert property (@(posedge clk_ref)
        !sync_rst_n |=> !int_rst_n);

endmodule

// File: tb/rst_phase_clkgen_tb.sv
module rst_phase_clkgen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BOOT_W     = 3;
    localparam int N_GRP      = 4;
    localparam int STRETCH    = 16;
    localparam int WIN        = 64;

    logic              clk_ref = 1'b0;
    logic              rst_pin_n = 1'b0;
    logic              eclk_sel = 1'b0;
    logic [BOOT_W-1:0] boot_straps = 3'b101;
    logic              int_rst_n, ce_cpu, ce_per, ce_mem, clkout3, eclkout;
    logic [BOOT_W-1:0] boot_cfg;
    logic [N_GRP-1:0]  pin_oe;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int m_cpu, m_per, m_mem, m_r3, m_h3, m_re, m_he;
    int c0;

    rst_phase_clkgen #(.STRETCH_CYC(STRETCH), .BOOT_W(BOOT_W), .N_GRP(N_GRP)) u_dut (
        .clk_ref     (clk_ref),
        .rst_pin_n   (rst_pin_n),
        .eclk_sel    (eclk_sel),
        .boot_straps (boot_straps),
        .int_rst_n   (int_rst_n),
        .ce_cpu      (ce_cpu),
        .ce_per      (ce_per),
        .ce_mem      (ce_mem),
        .clkout3     (clkout3),
        .eclkout     (eclkout),
        .boot_cfg    (boot_cfg),
        .pin_oe      (pin_oe)
    );

    always #(CLK_PERIOD/2) clk_ref = ~clk_ref;
    always @(posedge clk_ref) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_ref);
    endtask

    // Sample one window at negedges: enable counts, rising edges and high counts.
    task automatic measure();
        logic p3, pe;
        m_cpu = 0; m_per = 0; m_mem = 0; m_r3 = 0; m_h3 = 0; m_re = 0; m_he = 0;
        p3 = clkout3; pe = eclkout;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk_ref);
            m_cpu += int'(ce_cpu); m_per += int'(ce_per); m_mem += int'(ce_mem);
            m_h3 += int'(clkout3); m_he += int'(eclkout);
            if (clkout3 && !p3) m_r3++;
            if (eclkout && !pe) m_re++;
            p3 = clkout3; pe = eclkout;
        end
    endtask

    // Wait for the internal reset to release; returns edges since c0, or -1.
    task automatic wait_release(output int k);
        int guard;
        guard = 0;
        while (!int_rst_n && guard < 1000) begin
            @(negedge clk_ref);
            guard++;
        end
        k = int_rst_n ? (cyc - c0) : -1;
    endtask

    initial begin
        int k;
        wait_cycles(20);
        // R1: reset state while the pin is low
        check(int_rst_n == 1'b0, "R1 int_rst_n low", int'(int_rst_n), 0);
        check(pin_oe == '0, "R1 pin_oe low", int'(pin_oe), 0);
        check(boot_cfg == '0, "R1 boot_cfg cleared", int'(boot_cfg), 0);

        measure();
        check(m_cpu == 8, "R2 phase1 ce_cpu", m_cpu, 8);
        check(m_per == 8, "R2 phase1 ce_per", m_per, 8);
        check(m_mem == 8, "R2 phase1 ce_mem", m_mem, 8);
        check(m_r3 == 8 && m_h3 == 32, "R5 phase1 clkout3 rises", m_r3, 8);
        check(m_re == 8, "R10 phase1 eclkout rises", m_re, 8);

        // Release the pin; change the straps a few cycles later.
        c0 = cyc;
        rst_pin_n = 1'b1;
        wait_cycles(6);
        boot_straps = 3'b010;
        wait_cycles(4);
        measure();
        check(m_cpu == 8 && m_per == 8 && m_mem == 8, "R2 phase2 enables", m_cpu + m_per + m_mem, 24);
        check(pin_oe == '0, "R8 phase2 pin_oe low", int'(pin_oe), 0);
        check(int_rst_n == 1'b0, "R6 still stretched", int'(int_rst_n), 0);

        wait_release(k);
        check(k >= 8*STRETCH - 4 && k <= 8*STRETCH + 3, "R6 stretch length", k, 8*STRETCH);
        check(clkout3 == 1'b0 && eclkout == 1'b0, "R9 levels low at switch",
              int'({clkout3, eclkout}), 0);
        check(pin_oe == {N_GRP{1'b1}}, "R8 phase3 pin_oe high", int'(pin_oe), (1 << N_GRP) - 1);
        check(boot_cfg == 3'b101, "R7 boot latched at release", int'(boot_cfg), 5);

        measure();
        check(m_cpu == WIN, "R3 phase3 ce_cpu", m_cpu, WIN);
        check(m_per == WIN/2, "R4 phase3 ce_per", m_per, WIN/2);
        check(m_mem == WIN/2, "R4 phase3 ce_mem", m_mem, WIN/2);
        check(m_r3 == 8 && m_h3 == 32, "R5 phase3 clkout3 rises", m_r3, 8);
        check(m_re == WIN/2, "R10 phase3 eclkout rises", m_re, WIN/2);

        eclk_sel = 1'b1;
        wait_cycles(2);
        measure();
        check(m_he == 0, "R10 eclkout held low when selected off", m_he, 0);
        check(m_r3 == 8, "R5 clkout3 with eclk_sel=1", m_r3, 8);
        eclk_sel = 1'b0;
        boot_straps = 3'b011;
        wait_cycles(5);
        check(boot_cfg == 3'b101, "R7 boot held after straps change", int'(boot_cfg), 5);

        // R11: reset re-applied from phase 3
        rst_pin_n = 1'b0;
        @(negedge clk_ref);
        check(int_rst_n == 1'b0, "R11 int_rst_n after reassert", int'(int_rst_n), 0);
        check(pin_oe == '0, "R11 pin_oe after reassert", int'(pin_oe), 0);
        wait_cycles(20);
        measure();
        check(m_cpu == 8 && m_mem == 8, "R2 phase1 after reassert", m_cpu + m_mem, 16);
        check(m_re == 8, "R10 phase1 eclkout after reassert", m_re, 8);

        // Second release with straps 011 held through it.
        c0 = cyc;
        rst_pin_n = 1'b1;
        wait_release(k);
        check(k >= 8*STRETCH - 4 && k <= 8*STRETCH + 3, "R6 second stretch length", k, 8*STRETCH);
        check(boot_cfg == 3'b011, "R7 new boot value latched", int'(boot_cfg), 3);
        boot_straps = 3'b111;
        wait_cycles(30);
        check(boot_cfg == 3'b011, "R7 boot held in phase3", int'(boot_cfg), 3);

        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

endmodule